// File: doc/BRIEF.md
# Busy-Indicating Serial Converter Device Model

This block is a synthesizable stand-in for the digital side of a successive-approximation converter. Its serial port signals the end of each conversion by starting to drive its data line. A host controller under test connects to it exactly as it would to the real converter. A rising edge on the convert line starts a fixed-length conversion. A sample presented on a parallel input is captured at that edge. While the conversion runs, the data line is released. When the conversion finishes, the device drives the data line with the most significant result bit. That transition is the interrupt a host with a pull-up on the line would see.

The host then clocks the result out on falling serial-clock edges. The device can also take a 14-bit configuration word, shifted in most-significant-bit first on rising serial-clock edges. This happens in one of two windows:

- **During a conversion.** The load is armed when the serial clock is high at the instant the convert line rises.
- **During the first 14 clocks of a readout.**

A word taken during conversion n becomes active when that conversion ends. A word taken during a readout waits one more conversion before it becomes active. All inputs are sampled on the system clock, so the serial clock must be much slower than it.

Top module: `sar_serial_model`

## Requirements
- R1: After reset the data output enable is low and the active configuration equals the parameter CFG_RST (all ones by default).
- R2: A convert rising edge seen outside a conversion starts a new conversion, and the data output enable is low in the very next cycle; this also ends a readout that is in progress.
- R3: The conversion ends exactly CONV_CYCLES system-clock cycles after the edge that started it; convert rising edges during the conversion have no effect, and the output enable stays low until the end.
- R4: When the conversion ends the output enable goes high and the data output presents bit 15 of the sample that was on the sample input at the starting edge.
- R5: Each serial-clock falling edge during a readout moves the data output to the next lower sample bit (bit 0 after the 15th fall, 0 after the 16th); the 17th fall drops the output enable.
- R6: If the serial clock is high at the starting edge, the next 14 serial-clock rising edges of that conversion shift in a configuration word, MSB first; it becomes the active configuration in the cycle the conversion ends and not before.
- R7: If the serial clock is low at the starting edge, serial-clock rising edges during that conversion do not change the configuration.
- R8: An armed load that has fewer than 14 bits when the conversion ends is discarded, and the previous configuration stays active.
- R9: The first 14 serial-clock rising edges after a conversion ends form a pending word, MSB first; the active configuration is unchanged until the following conversion ends, when the pending word becomes active.
- R10: When a complete armed load and a pending readout word both exist at the end of a conversion, the armed load becomes active and the pending word is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_in | input | 1 | Convert line; a rising edge starts a conversion |
| sclk_in | input | 1 | Serial clock from the host |
| din_in | input | 1 | Serial configuration data from the host |
| sample_in | input | DATA_W | Value captured as the conversion result |
| sdo_out | output | 1 | Serial result data |
| sdo_oe | output | 1 | High while the data output is driven, low while it is released |
| cfg_out | output | CFG_W | Active configuration word |

## Verification
The bench goes after the edges of the configuration path:

- **Armed load completing late in a conversion.** A model that applies the word as soon as the 14th bit arrives would change the configuration before the end of conversion.
- **Load that stops after nine bits.** A model that does not count bits would install a truncated, shifted word.
- **Readout word applied too early.** A readout word applied at the next conversion start, rather than its end, would show up one check early.
- **Readout word winning over an armed load.** If the readout word took priority, the wrong value would be active after the third conversion.

On the timing side, a convert pulse in the middle of a conversion checks that an off-by-one or restartable timer would move the release point. A readout cut short by a new conversion checks that the output is released at once. The 16th and 17th falls check that a counter one off would either drop the output too soon or hold it too long.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    // Phase of the device: converting, or acquiring/reading out.
    typedef enum logic {
        PH_ACQ  = 1'b0,
        PH_CONV = 1'b1
    } phase_t;
endpackage

// File: rtl/ssm_edges.sv
// ssm_edges: registers the convert and serial-clock lines once and flags
// their transitions for one system-clock cycle.
// Assumes both lines are already synchronous to clk.
module ssm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_in,
    input  logic sclk_in,
    output logic conv_rise,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic conv_q;
    logic sclk_q;

    // Hold the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            conv_q <= conv_in;
            sclk_q <= sclk_in;
        end
    end

    assign conv_rise = conv_in & ~conv_q;
    assign sclk_rise = sclk_in & ~sclk_q;
    assign sclk_fall = ~sclk_in & sclk_q;
endmodule

// File: rtl/ssm_timer.sv
// ssm_timer: conversion timer. A start pulse runs it for CYCLES clock
// cycles; done is high in the last of them.
// Assumes start arrives only while idle (the top gates it).
module ssm_timer #(
    parameter int CYCLES = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] remain;

    // Count the remaining cycles of a running conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= LOAD;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign done = busy && (remain == '0);
endmodule

// File: rtl/ssm_cfg.sv
// ssm_cfg: configuration capture. A load armed at conversion start takes
// CFG_W rising serial-clock edges during the conversion. In acquisition,
// the first CFG_W rises form a pending word. At conversion end a complete
// armed word wins, otherwise a pending word is applied.
// Assumes start and done never coincide.
module ssm_cfg
    import ssm_pkg::*;
#(
    parameter int              CFG_W   = 14,
    parameter logic [CFG_W-1:0] CFG_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic             start,
    input  logic             arm_lvl,
    input  logic             done,
    input  logic             sclk_rise,
    input  logic             din,
    output logic [CFG_W-1:0] cfg
);
    localparam int CNT_W = $clog2(CFG_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_W);

    logic [CFG_W-1:0] shreg;
    logic [CFG_W-1:0] pend;
    logic             pend_v;
    logic             armed;
    logic [CNT_W-1:0] nbits;
    logic             take;
    logic [CFG_W-1:0] shifted;

    assign take    = sclk_rise && (nbits != FULL) && ((phase == PH_ACQ) || armed);
    assign shifted = {shreg[CFG_W-2:0], din};

    // Shift in, stage and apply configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= CFG_RST;
            shreg  <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
            armed  <= 1'b0;
            nbits  <= '0;
        end else if (start) begin
            armed <= arm_lvl;
            nbits <= '0;
        end else if (done) begin
            if (armed && (nbits == FULL)) begin
                cfg <= shreg;
            end else if (pend_v) begin
                cfg <= pend;
            end
            pend_v <= 1'b0;
            armed  <= 1'b0;
            nbits  <= '0;
        end else if (take) begin
            shreg <= shifted;
            nbits <= nbits + 1'b1;
            if ((phase == PH_ACQ) && (nbits == FULL - 1'b1)) begin
                pend   <= shifted;
                pend_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssm_shift.sv
// ssm_shift: result path. Latches the sample at start, loads it at done,
// and drives it out MSB first, one bit per falling serial-clock edge.
// The DATA_W+1-th fall releases the line.
// Assumes start and done never coincide.
module ssm_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] sample,
    output logic              sdo,
    output logic              oe
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] sreg;
    logic [CNT_W-1:0]  falls;

    // Capture the sample, present it, and advance it on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= '0;
            sreg  <= '0;
            oe    <= 1'b0;
            falls <= '0;
        end else if (start) begin
            hold <= sample;
            oe   <= 1'b0;
        end else if (done) begin
            sreg  <= hold;
            oe    <= 1'b1;
            falls <= '0;
        end else if (oe && sclk_fall) begin
            if (falls == LAST) begin
                oe <= 1'b0;
            end else begin
                sreg  <= {sreg[DATA_W-2:0], 1'b0};
                falls <= falls + 1'b1;
            end
        end
    end

    assign sdo = sreg[DATA_W-1];
endmodule

// File: rtl/sar_serial_model.sv
// sar_serial_model: device-side model of a converter serial port that
// signals end of conversion by starting to drive its data line.
// Assumes conv_in, sclk_in and din_in are synchronous to clk, and each
// serial-clock level lasts at least one clk cycle.
module sar_serial_model
    import ssm_pkg::*;
#(
    parameter int               DATA_W      = 16,
    parameter int               CFG_W       = 14,
    parameter int               CONV_CYCLES = 80,
    parameter logic [CFG_W-1:0] CFG_RST     = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_in,
    input  logic              sclk_in,
    input  logic              din_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic [CFG_W-1:0]  cfg_out
);
    logic   conv_rise;
    logic   sclk_rise;
    logic   sclk_fall;
    logic   conv_start;
    logic   conv_done;
    logic   busy;
    phase_t phase;

    ssm_edges i_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_in   (conv_in),
        .sclk_in   (sclk_in),
        .conv_rise (conv_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    // A convert edge only counts outside a running conversion.
    assign conv_start = conv_rise && !busy;
    assign phase      = busy ? PH_CONV : PH_ACQ;

    ssm_timer #(.CYCLES(CONV_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .busy  (busy),
        .done  (conv_done)
    );

    ssm_cfg #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .start     (conv_start),
        .arm_lvl   (sclk_in),
        .done      (conv_done),
        .sclk_rise (sclk_rise),
        .din       (din_in),
        .cfg       (cfg_out)
    );

    ssm_shift #(.DATA_W(DATA_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (conv_start),
        .done      (conv_done),
        .sclk_fall (sclk_fall),
        .sample    (sample_in),
        .sdo       (sdo_out),
        .oe        (sdo_oe)
    );
endmodule

// File: rtl/sar_serial_model_chk.sv
// sar_serial_model_chk: temporal checks on the converter model. It is
// bound into every instance of the top module.
module sar_serial_model_chk #(
    parameter int CFG_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             conv_done,
    input logic             busy,
    input logic             sclk_fall,
    input logic             sdo_oe,
    input logic [CFG_W-1:0] cfg_out
);
    // R2: a started conversion releases the data line next cycle.
    a_r2_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !sdo_oe);

    // R3: the line is never driven while the timer runs.
    a_r3_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sdo_oe);

    // R4: the end of conversion drives the line.
    a_r4_drive_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> sdo_oe);

    // R5: the line is released only by a new conversion or a falling edge.
    a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> $past(conv_start || sclk_fall));

    // R6: the configuration moves only at the end of a conversion.
    a_r6_cfg_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(cfg_out));
endmodule

bind sar_serial_model sar_serial_model_chk #(.CFG_W(CFG_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .busy       (busy),
    .sclk_fall  (sclk_fall),
    .sdo_oe     (sdo_oe),
    .cfg_out    (cfg_out)
);

// File: tb/test_sar_serial_model.sv
`timescale 1ns/1ps
module test_sar_serial_model;
    localparam int CONV = 80;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv;
    logic        sclk;
    logic        din;
    logic [15:0] sample;
    logic        sdo;
    logic        oe;
    logic [13:0] cfg;

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] exp_q[$];
    logic [15:0] got_word;
    logic [15:0] last_smp;
    logic [13:0] cur_cfg;
    event        rd_ev;

    always #10 clk = ~clk;

    sar_serial_model #(.DATA_W(16), .CFG_W(14), .CONV_CYCLES(CONV)) i_sar_serial_model (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_in   (conv),
        .sclk_in   (sclk),
        .din_in    (din),
        .sample_in (sample),
        .sdo_out   (sdo),
        .sdo_oe    (oe),
        .cfg_out   (cfg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares each completed readout with the queued sample.
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                chk("R4 unexpected readout", 1, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk("R4 R5 readout word", {16'h0, got_word}, {16'h0, e});
            end
        end
    end

    // Driver: one conversion, with an optional configuration load and
    // an optional convert pulse in the middle.
    task automatic do_conv(input bit arm, input int nbits, input logic [13:0] word,
                           input bit toggle, input logic [15:0] smp,
                           input logic [13:0] cfg_after, input string tag);
        int el;
        sample = smp;
        sclk   = arm;
        conv   = 1'b1;
        tick(1);
        el = 1;
        chk("R2 output released after start", oe, 0);
        sample   = ~smp;
        conv     = 1'b0;
        last_smp = smp;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            din  = word[13-i];
            tick(2);
            sclk = 1'b1;
            tick(2);
            el += 4;
        end
        sclk = 1'b0;
        tick(1);
        el++;
        if (toggle) begin
            conv = 1'b1;
            tick(2);
            conv = 1'b0;
            tick(2);
            el += 4;
            chk("R3 convert pulse ignored", oe, 0);
        end
        tick(CONV - el);
        chk("R3 still converting one cycle before end", oe, 0);
        chk("R6 cfg unchanged before end", cfg, cur_cfg);
        tick(1);
        chk("R3 output driven at end", oe, 1);
        chk("R4 msb presented first", sdo, smp[15]);
        chk(tag, cfg, cfg_after);
        cur_cfg = cfg_after;
    endtask

    // Full readout of 17 clocks, shifting a word in on the first 14 rises.
    task automatic read_full(input logic [13:0] cap);
        logic [15:0] got;
        exp_q.push_back(last_smp);
        got[15] = sdo;
        for (int k = 1; k <= 17; k++) begin
            sclk = 1'b1;
            din  = (k <= 14) ? cap[14-k] : 1'b0;
            tick(2);
            sclk = 1'b0;
            tick(2);
            if (k <= 15) got[15-k] = sdo;
            if (k == 16) begin
                chk("R5 zero after 16 falls", sdo, 0);
                chk("R5 still driven after 16 falls", oe, 1);
            end
            if (k == 17) chk("R5 released on 17th fall", oe, 0);
        end
        got_word = got;
        ->rd_ev;
        tick(1);
    endtask

    task automatic read_partial(input int n);
        for (int k = 1; k <= n; k++) begin
            sclk = 1'b1;
            din  = 1'b1;
            tick(2);
            sclk = 1'b0;
            tick(2);
            chk("R5 partial readout bit", sdo, last_smp[15-k]);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        conv   = 1'b0;
        sclk   = 1'b0;
        din    = 1'b0;
        sample = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 output released after reset", oe, 0);
        chk("R1 reset configuration", cfg, 14'h3FFF);
        cur_cfg = 14'h3FFF;

        do_conv(1'b0, 14, 14'h2AAA, 1'b1, 16'hA5C3, 14'h3FFF, "R7 unarmed clocks ignored");
        read_full(14'h1234);
        chk("R9 cfg kept after readout capture", cfg, 14'h3FFF);

        do_conv(1'b0, 0, 14'h0, 1'b0, 16'h0001, 14'h1234, "R9 readout word applied after next conversion");
        read_full(14'h0ABC);

        do_conv(1'b1, 14, 14'h2D2D, 1'b0, 16'h8000, 14'h2D2D, "R6 R10 armed word wins");
        read_partial(3);

        do_conv(1'b1, 9, 14'h1555, 1'b0, 16'h7FFE, 14'h2D2D, "R8 short load discarded");
        read_full(14'h0000);

        do_conv(1'b0, 0, 14'h0, 1'b0, 16'hFFFF, 14'h0000, "R9 zero word applied");
        read_full(14'h3FFF);

        tick(2);
        summary();
        $finish;
    end
endmodule